// File: doc/BRIEF.md
# Bus and Pin Wake-Up Detector

This block sits beside the mode controller of a single-wire bus transceiver. It watches two digitized inputs, the bus receiver output (high = recessive, low = dominant) and a local wake pin. From them it raises wake-up events that move the controller out of its low-power states.

A remote wake-up is a complete bus gesture. The bus must go from recessive to dominant, stay dominant for longer than a programmable minimum, and then be released to recessive. A local wake-up is any debounced change of level on the wake pin, and it counts only while the controller is asleep. The remote gesture is honoured in both sleep and standby.

Every event comes out as a one-cycle pulse with a source tag. A sticky remote flag lets the receive-data pin be held low after a bus wake until a normal mode is entered. Both inputs pass through synchronizers. The two time limits are set in microseconds and converted to clock cycles from the clock frequency parameter.

Top module: `wake_detector`

## Requirements
- R1: During and after reset, `wake_o`, `wake_remote_o` and `remote_seen_o` are low. `mode_i` is encoded as 2'b00 sleep, 2'b01 standby, 2'b10 normal and 2'b11 normal with low slope.
- R2: In sleep or standby, consider a bus run that starts recessive, then stays dominant (`bus_rx_i`=0) for more than DOM_CYC consecutive cycles, then returns to recessive. It yields exactly one single-cycle `wake_o` pulse, and `wake_remote_o` is high in that same cycle.
- R3: A dominant run of DOM_CYC cycles or fewer, followed by recessive, yields no event.
- R4: A dominant level that is never released yields no event, however long it lasts.
- R5: Bus activity of any kind yields no event while `mode_i` selects either normal mode.
- R6: In sleep, a new level on `wake_pin_i` that holds for at least DEB_CYC consecutive cycles yields exactly one single-cycle `wake_o` pulse with `wake_remote_o` low. A high pulse that lasts long enough therefore yields two events, one for each edge.
- R7: A level change on `wake_pin_i` that lasts fewer than DEB_CYC cycles yields no event.
- R8: Wake pin changes in standby or normal mode yield no event. The debounced level still follows the pin, so a change made outside sleep is not reported after a later return to sleep.
- R9: `remote_seen_o` rises together with a remote wake pulse and holds. It clears on the first clock edge at which a normal mode is selected. A local wake never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Current controller mode (encoding in R1) |
| bus_rx_i | input | 1 | Digitized bus receiver output, 0 = dominant |
| wake_pin_i | input | 1 | Digitized local wake pin |
| wake_o | output | 1 | One-cycle wake event |
| wake_remote_o | output | 1 | High with `wake_o` when the bus caused the event |
| remote_seen_o | output | 1 | Sticky flag: last wake came from the bus |

## Verification
The assertions assume that `mode_i` holds one of its four codes and is driven synchronously. They also assume that the bus is recessive out of reset, so that the first dominant sample is a genuine falling edge. The stimulus changes the inputs only at falling clock edges and holds each level for an exact number of cycles. Every dominant run and wake pin pulse therefore has a known length on both sides of the DOM_CYC and DEB_CYC limits. Local and remote gestures are never interleaved, so no two wake pulses land in adjacent cycles.

// File: rtl/wkd_pkg.sv
package wkd_pkg;

    typedef enum logic [1:0] {
        MD_SLEEP   = 2'b00,
        MD_STANDBY = 2'b01,
        MD_NORMAL  = 2'b10,
        MD_NORM_LO = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        RW_ARM  = 2'b00,
        RW_IDLE = 2'b01,
        RW_LOW  = 2'b10,
        RW_HELD = 2'b11
    } rw_state_e;

    typedef struct packed {
        logic hit;
        logic remote;
    } wake_evt_t;

    function automatic int us_to_cycles(input int clk_khz, input int us);
        int c;
        c = (clk_khz * us) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic is_normal(input mode_e m);
        return (m == MD_NORMAL) || (m == MD_NORM_LO);
    endfunction

endpackage

// File: rtl/wkd_sync.sv
module wkd_sync #(
    parameter int         WIDTH   = 2,
    parameter int         STAGES  = 2,
    parameter logic [1:0] RST_VAL = 2'b00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= RST_VAL[WIDTH-1:0];
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wkd_debounce.sv
module wkd_debounce #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level_o,
    output logic edge_o
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic         primed;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed  <= 1'b0;
            level_o <= 1'b0;
            cnt     <= '0;
            edge_o  <= 1'b0;
        end else begin
            edge_o <= 1'b0;
            if (!primed) begin
                primed  <= 1'b1;
                level_o <= din;
                cnt     <= '0;
            end else if (din == level_o) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                level_o <= din;
                edge_o  <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: a reported edge always comes with a new debounced level
    a_r6_edge_moves_level: assert property (@(posedge clk) disable iff (rst)
        edge_o |-> (level_o != $past(level_o)));

    // R7: the qualification counter never runs past its limit
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/wkd_remote.sv
module wkd_remote
    import wkd_pkg::*;
#(
    parameter int DOM_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic dom_i,
    output logic evt_o
);
    localparam int W = $clog2(DOM_CYC + 1);
    localparam logic [W-1:0] LIMIT = W'(DOM_CYC);

    rw_state_e    state;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RW_ARM;
            cnt   <= '0;
            evt_o <= 1'b0;
        end else begin
            evt_o <= 1'b0;
            if (!en_i) begin
                state <= RW_ARM;
                cnt   <= '0;
            end else begin
                unique case (state)
                    RW_ARM: begin
                        if (!dom_i) state <= RW_IDLE;
                    end
                    RW_IDLE: begin
                        if (dom_i) begin
                            state <= RW_LOW;
                            cnt   <= W'(1);
                        end
                    end
                    RW_LOW: begin
                        if (!dom_i) begin
                            state <= RW_IDLE;
                            cnt   <= '0;
                        end else if (cnt == LIMIT) begin
                            state <= RW_HELD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RW_HELD: begin
                        if (!dom_i) begin
                            evt_o <= 1'b1;
                            state <= RW_IDLE;
                            cnt   <= '0;
                        end
                    end
                    default: state <= RW_ARM;
                endcase
            end
        end
    end

    // R3: the dominant-time counter stays within its limit
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    // R4: an event only follows a recessive sample
    a_r4_evt_on_release: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> !$past(dom_i));

    // R5: no event while disabled
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !$past(en_i) |-> !evt_o);
endmodule

// File: rtl/wake_detector.sv
module wake_detector
    import wkd_pkg::*;
#(
    parameter int CLK_KHZ = 1000,
    parameter int WAKE_US = 40,
    parameter int DEB_US  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       bus_rx_i,
    input  logic       wake_pin_i,
    output logic       wake_o,
    output logic       wake_remote_o,
    output logic       remote_seen_o
);
    localparam int DOM_CYC = us_to_cycles(CLK_KHZ, WAKE_US);
    localparam int DEB_CYC = us_to_cycles(CLK_KHZ, DEB_US);

    mode_e     mode;
    logic      asleep;
    logic      listening;
    logic [1:0] raw_in;
    logic [1:0] syn_in;
    logic      pin_level;
    logic      pin_edge;
    logic      bus_evt;
    wake_evt_t evt;

    assign mode      = mode_e'(mode_i);
    assign asleep    = (mode == MD_SLEEP);
    assign listening = !is_normal(mode);
    assign raw_in    = {bus_rx_i, wake_pin_i};

    // bit 1: bus (recessive at reset), bit 0: wake pin
    wkd_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn_in)
    );

    wkd_debounce #(.CYC(DEB_CYC)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .din     (syn_in[0]),
        .level_o (pin_level),
        .edge_o  (pin_edge)
    );

    wkd_remote #(.DOM_CYC(DOM_CYC)) u_rem (
        .clk   (clk),
        .rst   (rst),
        .en_i  (listening),
        .dom_i (!syn_in[1]),
        .evt_o (bus_evt)
    );

    always_comb begin
        evt.remote = bus_evt && listening;
        evt.hit    = evt.remote || (pin_edge && asleep);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_o        <= 1'b0;
            wake_remote_o <= 1'b0;
            remote_seen_o <= 1'b0;
        end else begin
            wake_o        <= evt.hit;
            wake_remote_o <= evt.remote;
            if (!listening)      remote_seen_o <= 1'b0;
            else if (evt.remote) remote_seen_o <= 1'b1;
        end
    end

    // R2: the source tag never appears without a wake pulse
    a_r2_tag_with_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_remote_o |-> wake_o);

    // R5: no wake pulse follows a cycle in a normal mode
    a_r5_no_wake_normal: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> !is_normal(mode_e'($past(mode_i))));

    // R8: local wakes only come out of sleep
    a_r8_local_sleep_only: assert property (@(posedge clk) disable iff (rst)
        (wake_o && !wake_remote_o) |-> ($past(mode_i) == 2'b00));

    // R9: the flag clears after a normal mode is selected
    a_r9_flag_clears: assert property (@(posedge clk) disable iff (rst)
        is_normal(mode) |=> !remote_seen_o);

    // R9: the flag only rises together with a remote wake
    a_r9_flag_source: assert property (@(posedge clk) disable iff (rst)
        $rose(remote_seen_o) |-> wake_remote_o);
endmodule

// File: tb/tb_wake_detector.sv
module tb_wake_detector;
    localparam int CLK_KHZ = 1000;
    localparam int WAKE_US = 40;
    localparam int DEB_US  = 16;
    localparam int DOM     = (CLK_KHZ * WAKE_US) / 1000;
    localparam int DEB     = (CLK_KHZ * DEB_US) / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b01;
    logic       bus = 1'b1;
    logic       pin = 1'b0;
    logic       wake_o, wake_remote_o, remote_seen_o;

    int checks = 0;
    int errors = 0;
    int n_wake = 0;
    int n_rem  = 0;

    always #4 clk = ~clk;

    wake_detector #(.CLK_KHZ(CLK_KHZ), .WAKE_US(WAKE_US), .DEB_US(DEB_US)) dut (
        .clk           (clk),
        .rst           (rst),
        .mode_i        (mode),
        .bus_rx_i      (bus),
        .wake_pin_i    (pin),
        .wake_o        (wake_o),
        .wake_remote_o (wake_remote_o),
        .remote_seen_o (remote_seen_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wake_o)        n_wake++;
            if (wake_remote_o) n_rem++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr();
        n_wake = 0;
        n_rem  = 0;
    endtask

    task automatic dom_run(input int len);
        bus = 1'b0;
        cyc(len);
        bus = 1'b1;
        cyc(8);
    endtask

    task automatic pin_pulse(input int len);
        pin = ~pin;
        cyc(len);
        pin = ~pin;
        cyc(DEB + 8);
    endtask

    task automatic go_mode(input logic [1:0] m);
        mode = m;
        cyc(3);
    endtask

    function automatic int exp_remote(input int len, input logic [1:0] m);
        return (len > DOM && m[1] == 1'b0) ? 1 : 0;
    endfunction

    function automatic int exp_local(input int len, input logic [1:0] m);
        return (len >= DEB && m == 2'b00) ? 2 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        cyc(4);
        // R1 outputs under reset
        chk("R1 wake in reset", int'(wake_o), 0);
        chk("R1 seen in reset", int'(remote_seen_o), 0);
        rst = 1'b0;
        cyc(6);
        chk("R1 wake after reset", int'(wake_o) + int'(wake_remote_o), 0);

        // R2 remote in sleep, just qualifying
        go_mode(2'b00); clr();
        dom_run(DOM + 1);
        chk("R2 sleep remote pulses", n_wake, 1);
        chk("R2 sleep remote tag", n_rem, 1);
        chk("R9 flag set", int'(remote_seen_o), 1);
        mode = 2'b10; cyc(1);
        chk("R9 flag cleared", int'(remote_seen_o), 0);

        // R3 boundary: exactly DOM dominant cycles
        go_mode(2'b01); clr();
        dom_run(DOM);
        chk("R3 boundary no wake", n_wake, 0);

        // R2/R5 remote in standby, then in normal
        clr(); dom_run(DOM + 5);
        chk("R5 standby remote", n_rem, 1);
        go_mode(2'b11); clr();
        dom_run(DOM + 5);
        chk("R5 normal ignores bus", n_wake, 0);

        // R4 stuck dominant
        go_mode(2'b00); clr();
        bus = 1'b0; cyc(3 * DOM);
        chk("R4 stuck dominant", n_wake, 0);
        mode = 2'b10; cyc(2); bus = 1'b1; cyc(8);
        chk("R4 release in normal", n_wake, 0);

        // R6 local in sleep, both edges
        go_mode(2'b00); clr();
        pin_pulse(DEB);
        chk("R6 local pulses", n_wake, 2);
        chk("R6 local tag low", n_rem, 0);
        chk("R9 local leaves flag", int'(remote_seen_o), 0);

        // R7 glitch
        clr(); pin_pulse(DEB - 1);
        chk("R7 short glitch", n_wake, 0);

        // R8 change in standby not reported later in sleep
        go_mode(2'b01); clr();
        pin = 1'b1; cyc(DEB + 6);
        go_mode(2'b00); cyc(DEB + 6);
        chk("R8 standby change", n_wake, 0);
        pin = 1'b0; cyc(DEB + 6);
        chk("R6 falling edge wakes", n_wake, 1);

        // random bus runs
        for (int t = 0; t < 24; t++) begin
            logic [1:0] m;
            int len;
            m   = 2'($urandom_range(0, 3));
            len = DOM - 3 + int'($urandom_range(0, 6));
            go_mode(m); clr();
            dom_run(len);
            chk("R2 random remote", n_rem, exp_remote(len, m));
            chk("R9 random flag", int'(remote_seen_o), exp_remote(len, m));
            go_mode(2'b10);
        end

        // random pin pulses
        for (int t = 0; t < 16; t++) begin
            logic [1:0] m;
            int len;
            m   = 2'($urandom_range(0, 3));
            len = DEB - 3 + int'($urandom_range(0, 6));
            go_mode(m); clr();
            pin_pulse(len);
            chk("R6 random local", n_wake, exp_local(len, m));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule